// File: doc/BRIEF.md
# Blocking Fully-Associative Line Cache

This block is a small cache that sits between several requester ports and a single memory port. It stores a fixed number of whole lines. Any line can live in any slot, and a slot is found by comparing the line-aligned address against every stored tag. Only one request is handled at a time. While that request is in progress, every port is refused. When the response goes out, the block is free again, and the same cycle can accept the next request.

An accepted request is looked up after a fixed access delay. A hit is served straight from the stored line. A miss that covers exactly one aligned line goes to memory unchanged. Any other miss is turned into a whole-line read. When that read returns, the original access is replayed against the newly filled line. If the store is full when a line is installed, a pseudo-randomly picked resident line is first written back to memory in full. Saturating counters record hits and misses.

Top module: `blk_cache`

## Requirements
- R1: From the edge that accepts a request until the cycle its response is presented, `req_ready` is low on every port.
- R2: When several ports request in the same cycle, the lowest-numbered one is accepted. The response is one-hot on `rsp_valid` and is raised only on the port that issued the request.
- R3: A hit's response is presented LATENCY+1 clock edges after the edge that accepted it.
- R4: Byte k of `req_wdata` and of `rsp_rdata` corresponds to line byte (offset+k), for k below the request size. The offset is the address bits below the line size. A read returns these bytes with all higher bytes zero. A write hit merges exactly these bytes into the line. A write response carries zero data.
- R5: A miss at offset 0 with size equal to the line size is sent to memory unchanged. A read is sent as a read, and a write is sent as a write carrying its data. `mem_req_evict` is low on these requests. The line is then installed, so the next access to it hits.
- R6: Any other miss sends a whole-line read (`mem_req_write` low) at the line-aligned address. After the fill, a read returns the requested bytes of the filled line. A write merges its bytes into the filled line.
- R7: A miss that finds all slots occupied first issues a full-line write with `mem_req_evict` high. This write goes to the address of a resident line and carries that line's current contents. The evicted line misses on its next access.
- R8: In the cycle a response is presented, a waiting port sees `req_ready` high and can be accepted.
- R9: A request with size 0, or with offset plus size greater than the line size, is answered with `rsp_err` high after the normal lookup delay. It causes no memory traffic and does not change the counters.
- R10: `hit_count` and `miss_count` hold at all-ones instead of wrapping.
- R11: After reset, no response or memory request is active, both counters are zero, and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request present, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle, per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, per port |
| req_addr | input | NUM_PORTS*ADDR_W | Byte address, port p in slice p |
| req_size | input | NUM_PORTS*SIZE_W | Access size in bytes, per port |
| req_wdata | input | NUM_PORTS*LINE_W | Write bytes, byte k lands at offset+k |
| rsp_valid | output | NUM_PORTS | Response strobe to the issuing port |
| rsp_err | output | 1 | Response carries an illegal-span error |
| rsp_rdata | output | LINE_W | Read bytes, byte k from offset+k |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_evict | output | 1 | Write-back of an evicted line, no answer expected |
| mem_req_addr | output | ADDR_W | Line-aligned memory address |
| mem_req_wdata | output | LINE_W | Whole-line write data |
| mem_rsp_valid | input | 1 | Memory answer for a non-evict request |
| mem_rsp_rdata | input | LINE_W | Whole-line read data |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The lookup is tested with several access patterns. Full aligned reads and writes separate the forwarded path from the upgraded path. Partial reads and writes that hit or miss at odd offsets show whether byte lanes are placed correctly and whether the replay happens after a fill. Filling all slots and then missing again exposes the write-back, which is checked against a shadow memory. Going back to the evicted line confirms that it was removed. Two ports requesting together test priority, refusal while busy and acceptance in the response cycle. Illegal spans and long runs of hits or misses test the error path and counter saturation.

// File: rtl/blk_cache_pkg.sv
package blk_cache_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_LOOK,
    S_MREQ,
    S_MRSP,
    S_WB,
    S_INST,
    S_RESP
  } cache_state_t;
endpackage

// File: rtl/blk_cache_arb.sv
module blk_cache_arb #(
  parameter int NUM_PORTS = 2
) (
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] grant
);
  logic [NUM_PORTS-1:0] lower;

  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_pri
      if (g == 0) begin : g_first
        assign lower[g] = 1'b0;
      end else begin : g_rest
        assign lower[g] = lower[g-1] | req[g-1];
      end
      assign grant[g] = req[g] & ~lower[g];
    end
  endgenerate
endmodule

// File: rtl/blk_cache_lfsr.sv
module blk_cache_lfsr #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    TAPS = 8'hB8,
  parameter logic [W-1:0]    SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) value <= SEED;
    else        value <= (value >> 1) ^ (value[0] ? TAPS : '0);
  end
endmodule

// File: rtl/blk_cache_store.sv
module blk_cache_store #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 9,
  parameter int LINE_W    = 64,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              look_hit,
  output logic [IDX_W-1:0]  look_idx,
  output logic              full,
  output logic [IDX_W-1:0]  free_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data
);
  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] match;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LINE_W-1:0]    data_q [NUM_LINES];

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (tag_q[g] == look_tag);
    end
  endgenerate

  always_comb begin
    look_idx = '0;
    free_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (match[i])    look_idx = IDX_W'(i);
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign look_hit = |match;
  assign full     = &valid_q;
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/blk_cache.sv
module blk_cache
  import blk_cache_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 8,
  parameter int ADDR_W     = 12,
  parameter int LATENCY    = 2,
  parameter int CNT_W      = 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SIZE_W    = OFF_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          req_valid,
  output logic [NUM_PORTS-1:0]          req_ready,
  input  logic [NUM_PORTS-1:0]          req_write,
  input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
  input  logic [NUM_PORTS*SIZE_W-1:0]   req_size,
  input  logic [NUM_PORTS*LINE_W-1:0]   req_wdata,
  output logic [NUM_PORTS-1:0]          rsp_valid,
  output logic                          rsp_err,
  output logic [LINE_W-1:0]             rsp_rdata,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic                          mem_req_write,
  output logic                          mem_req_evict,
  output logic [ADDR_W-1:0]             mem_req_addr,
  output logic [LINE_W-1:0]             mem_req_wdata,
  input  logic                          mem_rsp_valid,
  input  logic [LINE_W-1:0]             mem_rsp_rdata,
  output logic [CNT_W-1:0]              hit_count,
  output logic [CNT_W-1:0]              miss_count
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int PID_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int LAT_W = $clog2(LATENCY + 1);
  localparam int RND_W = 8;

  // ---- byte-lane arithmetic -------------------------------------------
  function automatic logic [LINE_W-1:0] merge_bytes(
    input logic [LINE_W-1:0] line, input logic [LINE_W-1:0] wdata,
    input logic [OFF_W-1:0] off, input logic [SIZE_W-1:0] size);
    logic [LINE_W-1:0] res;
    res = line;
    for (int k = 0; k < LINE_BYTES; k++)
      if (k < int'(size) && int'(off) + k < LINE_BYTES)
        res[(int'(off) + k) * 8 +: 8] = wdata[k * 8 +: 8];
    return res;
  endfunction

  function automatic logic [LINE_W-1:0] extract_bytes(
    input logic [LINE_W-1:0] line,
    input logic [OFF_W-1:0] off, input logic [SIZE_W-1:0] size);
    logic [LINE_W-1:0] res;
    res = '0;
    for (int k = 0; k < LINE_BYTES; k++)
      if (k < int'(size) && int'(off) + k < LINE_BYTES)
        res[k * 8 +: 8] = line[(int'(off) + k) * 8 +: 8];
    return res;
  endfunction

  function automatic logic span_bad(input logic [OFF_W-1:0] off,
                                    input logic [SIZE_W-1:0] size);
    return (size == '0) ||
           ((SIZE_W+1)'(off) + (SIZE_W+1)'(size) > (SIZE_W+1)'(LINE_BYTES));
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  // ---- state ----------------------------------------------------------
  cache_state_t       state_q;
  logic [LAT_W-1:0]   lat_q;
  logic [PID_W-1:0]   port_q;
  logic               write_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [SIZE_W-1:0]  size_q;
  logic [LINE_W-1:0]  wdata_q;
  logic               upg_q;
  logic [LINE_W-1:0]  fill_q;
  logic [IDX_W-1:0]   slot_q;
  logic [LINE_W-1:0]  rdata_q;
  logic               err_q;
  logic [CNT_W-1:0]   hit_q;
  logic [CNT_W-1:0]   miss_q;

  // ---- named internal events (observed by the checker) -----------------
  logic busy;
  logic ev_accept;
  logic ev_install;

  // ---- request selection ---------------------------------------------
  logic [NUM_PORTS-1:0] grant;
  logic [PID_W-1:0]     sel_pid;
  logic                 sel_write;
  logic [ADDR_W-1:0]    sel_addr;
  logic [SIZE_W-1:0]    sel_size;
  logic [LINE_W-1:0]    sel_wdata;

  blk_cache_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .req   (req_valid),
    .grant (grant)
  );

  always_comb begin
    sel_pid   = '0;
    sel_write = 1'b0;
    sel_addr  = '0;
    sel_size  = '0;
    sel_wdata = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (grant[i]) begin
        sel_pid   = PID_W'(i);
        sel_write = req_write[i];
        sel_addr  = req_addr[i*ADDR_W +: ADDR_W];
        sel_size  = req_size[i*SIZE_W +: SIZE_W];
        sel_wdata = req_wdata[i*LINE_W +: LINE_W];
      end
    end
  end

  assign busy       = !(state_q == S_IDLE || state_q == S_RESP);
  assign req_ready  = busy ? '0 : grant;
  assign ev_accept  = |req_ready;
  assign ev_install = (state_q == S_INST);

  // ---- decoded current request ---------------------------------------
  logic [OFF_W-1:0]  off_q;
  logic [TAG_W-1:0]  tag_q;
  logic              bad_q;
  logic              whole_q;

  assign off_q   = addr_q[OFF_W-1:0];
  assign tag_q   = addr_q[ADDR_W-1:OFF_W];
  assign bad_q   = span_bad(off_q, size_q);
  assign whole_q = (off_q == '0) && (size_q == SIZE_W'(LINE_BYTES));

  // ---- store ----------------------------------------------------------
  logic              look_hit;
  logic [IDX_W-1:0]  look_idx;
  logic              full;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [LINE_W-1:0] wr_data;
  logic [LINE_W-1:0] inst_line;
  logic [RND_W-1:0]  rnd;
  logic [IDX_W-1:0]  victim;

  assign inst_line = (upg_q && write_q) ? merge_bytes(fill_q, wdata_q, off_q, size_q)
                                        : fill_q;
  assign rd_idx  = (state_q == S_WB) ? slot_q : look_idx;
  assign wr_en   = ev_install ||
                   (state_q == S_LOOK && look_hit && write_q && !bad_q);
  assign wr_idx  = ev_install ? slot_q : look_idx;
  assign wr_data = ev_install ? inst_line
                              : merge_bytes(rd_data, wdata_q, off_q, size_q);

  blk_cache_store #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W),
    .LINE_W    (LINE_W),
    .IDX_W     (IDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_tag (tag_q),
    .look_hit (look_hit),
    .look_idx (look_idx),
    .full     (full),
    .free_idx (free_idx),
    .rd_idx   (rd_idx),
    .rd_tag   (rd_tag),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (tag_q),
    .wr_data  (wr_data)
  );

  blk_cache_lfsr #(.W(RND_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .value (rnd)
  );

  assign victim = IDX_W'(rnd % RND_W'(NUM_LINES));

  // ---- memory side ------------------------------------------------------
  assign mem_req_valid = (state_q == S_MREQ) || (state_q == S_WB);
  assign mem_req_evict = (state_q == S_WB);
  assign mem_req_write = (state_q == S_WB) || (write_q && !upg_q);
  assign mem_req_addr  = (state_q == S_WB) ? {rd_tag, {OFF_W{1'b0}}}
                                           : {tag_q,  {OFF_W{1'b0}}};
  assign mem_req_wdata = (state_q == S_WB) ? rd_data : wdata_q;

  // ---- response side ----------------------------------------------------
  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rsp
      assign rsp_valid[g] = (state_q == S_RESP) && (port_q == PID_W'(g));
    end
  endgenerate

  assign rsp_err    = err_q;
  assign rsp_rdata  = rdata_q;
  assign hit_count  = hit_q;
  assign miss_count = miss_q;

  // ---- sequencer ----------------------------------------------------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lat_q   <= '0;
      port_q  <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      upg_q   <= 1'b0;
      fill_q  <= '0;
      slot_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      hit_q   <= '0;
      miss_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE, S_RESP: begin
          if (ev_accept) begin
            port_q  <= sel_pid;
            write_q <= sel_write;
            addr_q  <= sel_addr;
            size_q  <= sel_size;
            wdata_q <= sel_wdata;
            lat_q   <= LAT_W'(LATENCY);
            state_q <= S_WAIT;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (lat_q <= LAT_W'(1)) state_q <= S_LOOK;
          else                    lat_q   <= lat_q - 1'b1;
        end
        S_LOOK: begin
          if (bad_q) begin
            err_q   <= 1'b1;
            rdata_q <= '0;
            state_q <= S_RESP;
          end else if (look_hit) begin
            hit_q   <= sat_inc(hit_q);
            err_q   <= 1'b0;
            rdata_q <= write_q ? '0 : extract_bytes(rd_data, off_q, size_q);
            state_q <= S_RESP;
          end else begin
            miss_q  <= sat_inc(miss_q);
            upg_q   <= !whole_q;
            state_q <= S_MREQ;
          end
        end
        S_MREQ: begin
          if (mem_req_ready) state_q <= S_MRSP;
        end
        S_MRSP: begin
          if (mem_rsp_valid) begin
            fill_q <= (write_q && !upg_q) ? wdata_q : mem_rsp_rdata;
            if (full) begin
              slot_q  <= victim;
              state_q <= S_WB;
            end else begin
              slot_q  <= free_idx;
              state_q <= S_INST;
            end
          end
        end
        S_WB: begin
          if (mem_req_ready) state_q <= S_INST;
        end
        S_INST: begin
          err_q   <= 1'b0;
          rdata_q <= write_q ? '0 : extract_bytes(fill_q, off_q, size_q);
          state_q <= S_RESP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_cache_chk.sv
module blk_cache_chk #(
  parameter int NUM_PORTS = 2,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int PID_W     = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] req_ready,
  input logic [NUM_PORTS-1:0] rsp_valid,
  input logic                 busy,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic                 mem_req_write,
  input logic [ADDR_W-1:0]    mem_req_addr,
  input logic                 ev_install,
  input logic                 look_hit,
  input logic [CNT_W-1:0]     hit_count,
  input logic [CNT_W-1:0]     miss_count
);
  logic [PID_W-1:0] exp_pid;

  always_ff @(posedge clk) begin
    if (!rst_n) exp_pid <= '0;
    else begin
      for (int i = 0; i < NUM_PORTS; i++)
        if (req_ready[i]) exp_pid <= PID_W'(i);
    end
  end

  assert_one_inflight_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req_ready == '0));

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  assert_resp_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> ($onehot(rsp_valid) && rsp_valid[exp_pid]));

  assert_mem_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  assert_replay_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_install |=> look_hit);

  assert_hit_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count == {CNT_W{1'b1}}) |=> (hit_count == {CNT_W{1'b1}}));

  assert_miss_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == {CNT_W{1'b1}}) |=> (miss_count == {CNT_W{1'b1}}));
endmodule

bind blk_cache blk_cache_chk #(
  .NUM_PORTS (NUM_PORTS),
  .CNT_W     (CNT_W),
  .ADDR_W    (ADDR_W),
  .PID_W     (PID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .ev_install    (ev_install),
  .look_hit      (look_hit),
  .hit_count     (hit_count),
  .miss_count    (miss_count)
);

// File: tb/blk_cache_tb.sv
`timescale 1ns/1ps
module blk_cache_tb;
  localparam int NP = 2;
  localparam int NL = 4;
  localparam int LB = 8;
  localparam int AW = 12;
  localparam int LAT = 2;
  localparam int CW = 4;
  localparam int LW = LB * 8;
  localparam int SW = 4;
  localparam int NLINES = 1 << (AW - 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0]    req_valid = '0;
  logic [NP-1:0]    req_ready;
  logic [NP-1:0]    req_write = '0;
  logic [NP*AW-1:0] req_addr  = '0;
  logic [NP*SW-1:0] req_size  = '0;
  logic [NP*LW-1:0] req_wdata = '0;
  logic [NP-1:0]    rsp_valid;
  logic             rsp_err;
  logic [LW-1:0]    rsp_rdata;
  logic             mem_req_valid;
  logic             mem_req_ready;
  logic             mem_req_write;
  logic             mem_req_evict;
  logic [AW-1:0]    mem_req_addr;
  logic [LW-1:0]    mem_req_wdata;
  logic             mem_rsp_valid;
  logic [LW-1:0]    mem_rsp_rdata;
  logic [CW-1:0]    hit_count;
  logic [CW-1:0]    miss_count;

  blk_cache #(.NUM_PORTS(NP), .NUM_LINES(NL), .LINE_BYTES(LB), .ADDR_W(AW),
              .LATENCY(LAT), .CNT_W(CW)) u_dut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [LW-1:0] ref_mem [NLINES];
  logic [LW-1:0] ext_mem [NLINES];
  bit            resident [NLINES];
  int n_rd = 0, n_wr = 0, n_wb = 0, wb_bad = 0;
  logic [AW-1:0] last_addr;
  logic          last_write;
  int            dly = 0, pend = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] pick(input logic [LW-1:0] line, input int off, input int sz);
    logic [LW-1:0] r = '0;
    for (int k = 0; k < sz; k++) r[8*k +: 8] = line[8*(off+k) +: 8];
    return r;
  endfunction

  function automatic logic [LW-1:0] put(input logic [LW-1:0] line, input logic [LW-1:0] wd,
                                        input int off, input int sz);
    logic [LW-1:0] r = line;
    for (int k = 0; k < sz; k++) r[8*(off+k) +: 8] = wd[8*k +: 8];
    return r;
  endfunction

  // memory model: ready drops for two cycles after each transfer, answers in three
  initial begin
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    for (int i = 0; i < NLINES; i++) begin
      ref_mem[i]  = (64'(i) * 64'h0101_0101_0101_0101) ^ 64'h0123_4567_89AB_CDEF;
      ext_mem[i]  = ref_mem[i];
      resident[i] = 1'b0;
    end
    forever begin
      @(posedge clk);
      mem_rsp_valid <= (pend == 1);
      if (pend != 0) pend <= pend - 1;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_evict) begin
          n_wb++;
          if (!resident[mem_req_addr[AW-1:3]] || mem_req_wdata != ref_mem[mem_req_addr[AW-1:3]])
            wb_bad++;
          resident[mem_req_addr[AW-1:3]] = 1'b0;
          ext_mem[mem_req_addr[AW-1:3]]  = mem_req_wdata;
        end else begin
          last_addr  = mem_req_addr;
          last_write = mem_req_write;
          if (mem_req_write) begin
            n_wr++;
            ext_mem[mem_req_addr[AW-1:3]] = mem_req_wdata;
          end else n_rd++;
          mem_rsp_rdata <= ext_mem[mem_req_addr[AW-1:3]];
          pend <= 3;
        end
        mem_req_ready <= 1'b0;
        dly <= 2;
      end else if (dly != 0) begin
        dly <= dly - 1;
        if (dly == 1) mem_req_ready <= 1'b1;
      end
    end
  end

  task automatic drive(input int p, input bit w, input logic [AW-1:0] a,
                       input int sz, input logic [LW-1:0] wd);
    req_write[p] = w;
    req_addr[p*AW +: AW] = a;
    req_size[p*SW +: SW] = SW'(sz);
    req_wdata[p*LW +: LW] = wd;
    req_valid[p] = 1'b1;
  endtask

  task automatic access(input int p, input bit w, input logic [AW-1:0] a, input int sz,
                        input logic [LW-1:0] wd, output logic [LW-1:0] rd,
                        output bit er, output int edges);
    @(negedge clk);
    drive(p, w, a, sz, wd);
    #1;
    while (!req_ready[p]) begin @(negedge clk); #1; end
    @(posedge clk);
    edges = 0;
    @(negedge clk);
    req_valid[p] = 1'b0;
    while (!rsp_valid[p]) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    rd = rsp_rdata;
    er = rsp_err;
    if (!er) begin
      if (w) ref_mem[a[AW-1:3]] = put(ref_mem[a[AW-1:3]], wd, int'(a[2:0]), sz);
      resident[a[AW-1:3]] = 1'b1;
    end
  endtask

  task automatic t_reset();
    chk(rsp_valid == '0 && mem_req_valid == 1'b0, "R11", "idle outputs",
        {rsp_valid, mem_req_valid}, '0);
    chk(hit_count == '0 && miss_count == '0, "R11", "counters", {hit_count, miss_count}, '0);
  endtask

  task automatic t_full_read_miss();
    logic [LW-1:0] rd; bit er; int e; int r0 = n_rd;
    access(0, 0, 12'h040, 8, '0, rd, er, e);
    chk(rd == ref_mem[8], "R5", "full read miss data", rd, ref_mem[8]);
    chk(n_rd == r0 + 1 && last_addr == 12'h040 && !last_write, "R5", "forwarded read",
        last_addr, 12'h040);
    chk(miss_count == 1, "R11", "first access misses", miss_count, 1);
  endtask

  task automatic t_hits();
    logic [LW-1:0] rd; bit er; int e;
    access(0, 0, 12'h042, 3, '0, rd, er, e);
    chk(e == LAT + 1, "R3", "hit latency", e, LAT + 1);
    chk(rd == pick(ref_mem[8], 2, 3), "R4", "partial read hit", rd, pick(ref_mem[8], 2, 3));
    chk(hit_count == 1, "R5", "line installed", hit_count, 1);
    access(1, 1, 12'h045, 2, 64'hBEEF, rd, er, e);
    chk(rd == '0 && !er, "R4", "write response data", rd, '0);
    access(0, 0, 12'h040, 8, '0, rd, er, e);
    chk(rd == ref_mem[8], "R4", "write hit merge", rd, ref_mem[8]);
  endtask

  task automatic t_partial_miss();
    logic [LW-1:0] rd; bit er; int e; int r0 = n_rd; int h0;
    access(1, 0, 12'h083, 4, '0, rd, er, e);
    chk(n_rd == r0 + 1 && last_addr == 12'h080 && !last_write, "R6", "upgraded read request",
        last_addr, 12'h080);
    chk(rd == pick(ref_mem[16], 3, 4), "R6", "replayed read", rd, pick(ref_mem[16], 3, 4));
    access(0, 1, 12'h0C1, 3, 64'h123456, rd, er, e);
    chk(last_addr == 12'h0C0 && !last_write, "R6", "write miss upgraded to read",
        {last_write, last_addr}, 12'h0C0);
    h0 = hit_count;
    access(0, 0, 12'h0C0, 8, '0, rd, er, e);
    chk(rd == ref_mem[24] && hit_count == h0 + 1, "R6", "replayed write merged", rd, ref_mem[24]);
  endtask

  task automatic t_full_write_miss();
    logic [LW-1:0] rd; bit er; int e; int w0 = n_wr; int b0 = n_wb;
    access(1, 1, 12'h100, 8, 64'hCAFE_F00D_1234_5678, rd, er, e);
    chk(n_wr == w0 + 1 && last_write && last_addr == 12'h100, "R5", "forwarded write",
        last_addr, 12'h100);
    chk(n_wb == b0, "R7", "no eviction while a slot is free", n_wb, b0);
    access(0, 0, 12'h100, 8, '0, rd, er, e);
    chk(rd == 64'hCAFE_F00D_1234_5678, "R5", "full write installed", rd, 64'hCAFE_F00D_1234_5678);
  endtask

  task automatic t_evict();
    logic [LW-1:0] rd; bit er; int e; int b0 = n_wb; int m0;
    logic [AW-1:3] gone [NLINES];
    int ngone = 0;
    bit was [NLINES];
    for (int i = 0; i < NLINES; i++) was[i] = resident[i];
    access(0, 0, 12'h140, 8, '0, rd, er, e);
    chk(n_wb == b0 + 1 && wb_bad == 0, "R7", "write-back of resident line", n_wb, b0 + 1);
    chk(rd == ref_mem[40], "R7", "data after eviction", rd, ref_mem[40]);
    for (int i = 0; i < NLINES; i++)
      if (was[i] && !resident[i]) begin gone[ngone] = (AW-3)'(i); ngone++; end
    chk(ngone == 1, "R7", "exactly one line evicted", ngone, 1);
    if (ngone == 1) begin
      m0 = miss_count;
      access(1, 0, {gone[0], 3'b000}, 8, '0, rd, er, e);
      chk(miss_count == m0 + 1 && rd == ref_mem[gone[0]], "R7", "evicted line misses",
          miss_count, m0 + 1);
    end
  endtask

  task automatic t_error();
    logic [LW-1:0] rd; bit er; int e;
    int t0 = n_rd + n_wr + n_wb; int h0 = hit_count; int m0 = miss_count;
    access(0, 0, 12'h146, 4, '0, rd, er, e);
    chk(er && e == LAT + 1, "R9", "span error flagged", {er, 32'(e)}, {1'b1, 32'(LAT + 1)});
    access(1, 1, 12'h300, 0, 64'hFF, rd, er, e);
    chk(er == 1'b1, "R9", "size zero flagged", er, 1);
    chk(n_rd + n_wr + n_wb == t0 && hit_count == h0 && miss_count == m0, "R9",
        "no traffic or counting", {hit_count, miss_count}, {4'(h0), 4'(m0)});
  endtask

  task automatic t_contend();
    int held = 0;
    @(negedge clk);
    drive(0, 0, 12'h140, 8, '0);
    drive(1, 0, 12'h141, 2, '0);
    #1;
    chk(req_ready == 2'b01, "R2", "lowest port wins", req_ready, 2'b01);
    @(posedge clk);
    @(negedge clk);
    req_valid[0] = 1'b0;
    #1;
    while (!rsp_valid[0]) begin
      if (req_ready[1]) held++;
      @(negedge clk); #1;
    end
    chk(held == 0, "R1", "other port refused while busy", held, 0);
    chk(rsp_valid == 2'b01 && rsp_rdata == ref_mem[40], "R2", "response to port 0",
        {rsp_valid, rsp_rdata}, {2'b01, ref_mem[40]});
    chk(req_ready[1] == 1'b1, "R8", "accept in response cycle", req_ready, 2'b10);
    @(posedge clk);
    @(negedge clk);
    req_valid[1] = 1'b0;
    while (!rsp_valid[1]) @(negedge clk);
    chk(rsp_valid == 2'b10 && rsp_rdata == pick(ref_mem[40], 1, 2), "R2", "response to port 1",
        {rsp_valid, rsp_rdata}, {2'b10, pick(ref_mem[40], 1, 2)});
  endtask

  task automatic t_saturate();
    logic [LW-1:0] rd; bit er; int e;
    for (int i = 0; i < 20; i++) access(0, 0, 12'h140, 8, '0, rd, er, e);
    chk(hit_count == 4'hF, "R10", "hit counter holds", hit_count, 4'hF);
    for (int i = 0; i < 16; i++) access(1, 0, AW'(12'h400 + 8 * i), 8, '0, rd, er, e);
    chk(miss_count == 4'hF, "R10", "miss counter holds", miss_count, 4'hF);
    chk(wb_bad == 0, "R7", "all write-backs carried resident data", wb_bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_read_miss();
    t_hits();
    t_partial_miss();
    t_full_write_miss();
    t_evict();
    t_error();
    t_contend();
    t_saturate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule